// File: doc/BRIEF.md
# Multi-Port Hardware Spin-Lock Bank

A shared peripheral that gives several processors mutual exclusion using only plain loads and stores. Every processor reaches the bank through its own small slave port, which has a lock index, a read strobe, a write strobe and a read-data word. Reading a lock is a test-and-take in one access: the read returns 1 when the lock was free and is now held by the reading port, and returns 0 when someone else already holds it. Writing to a lock hands it back.

Each lock remembers which port took it, so only that port can free it. When several ports read the same free lock in one cycle, an internal per-lock arbiter picks the lowest-numbered port. Ports that touch different locks never wait for one another. Software builds its critical sections and mutexes on top of this: spin on a read until it returns 1, do the protected work, then write to release.

Top module: `spinlock_bank`

## Requirements
- R1: The bank holds 16 independent locks (default), each selected by a 4-bit lock index on a port's address; each port has its own index, read strobe, write strobe and read-data word.
- R2: A read of a free lock returns read data 1 and leaves that lock held, owned by the reading port.
- R3: A read of a held lock returns read data 0 and changes neither the held state nor the owner of that lock.
- R4: A write from the owning port to a held lock frees it, so the next read of it returns 1.
- R5: A write from a port that does not own the lock, or a write to a free lock, has no effect on that lock.
- R6: When several ports read the same free lock in one cycle, the lowest-numbered of them gets 1 and becomes owner; every other one gets 0.
- R7: Accesses by different ports to different locks in the same cycle are each served as if alone, with no stall.
- R8: Read data appears on the clock edge after the read strobe, on every port; after a cycle with no read, that port's read data is 0.
- R9: After reset every lock is free and has no owner, and every read-data word is 0.
- R10: When the owner writes a lock in the same cycle as another port reads it, the read returns 0 and the lock is free afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_addr_i | input | NUM_PORTS*IDX_W | Lock index per port, port p at bits [p*IDX_W +: IDX_W] |
| port_rd_i | input | NUM_PORTS | Read (test-and-take) strobe per port |
| port_wr_i | input | NUM_PORTS | Write (release) strobe per port |
| port_rdata_o | output | NUM_PORTS*DATA_W | Read data per port, 1 on a successful take, else 0 |

## Verification
The assertions take for granted that a port never raises its read and write strobes in the same cycle, and that the index on a port is only meaningful while one of its strobes is high. The directed stimulus drives at most one strobe per port per cycle, parks strobes low between accesses, and keeps indices in range. Under those conditions each lock's state only moves through a take by the arbiter's winner or a release by its recorded owner, which is what the properties in the lock cells follow.

// File: rtl/slk_pkg.sv
package slk_pkg;

  // Index of the lowest set bit, 0 when none is set.
  function automatic int unsigned lowest_index(input logic [31:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

  // Mask with every bit below position n set.
  function automatic logic [31:0] below_mask(input int unsigned n);
    return (32'h1 << n) - 32'h1;
  endfunction

endpackage

// File: rtl/slk_arbiter.sv
module slk_arbiter #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input  logic [NUM_PORTS-1:0] req_i,
  output logic [NUM_PORTS-1:0] grant_o,
  output logic [PORT_W-1:0]    winner_o,
  output logic                 any_o
);

  logic [PORT_W-1:0] winner;

  assign any_o    = |req_i;
  assign winner   = PORT_W'(slk_pkg::lowest_index(32'(req_i)));
  assign winner_o = winner;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      grant_o[p] = any_o && (winner == PORT_W'(p));
    end
  end

endmodule

// File: rtl/slk_lock_cell.sv
module slk_lock_cell #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] rd_hit_i,
  input  logic [NUM_PORTS-1:0] wr_hit_i,
  output logic [NUM_PORTS-1:0] grant_o
);

  logic              held_q;
  logic [PORT_W-1:0] owner_q;

  // Named internal events
  logic [NUM_PORTS-1:0] take_req;
  logic [PORT_W-1:0]    winner;
  logic                 acquire;
  logic                 release_ok;

  assign take_req = held_q ? '0 : rd_hit_i;

  slk_arbiter #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) arb_i (
    .req_i    (take_req),
    .grant_o  (grant_o),
    .winner_o (winner),
    .any_o    (acquire)
  );

  assign release_ok = held_q && wr_hit_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (acquire) begin
      held_q  <= 1'b1;
      owner_q <= winner;
    end else if (release_ok) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end
  end

  assert_acquire_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acquire |=> held_q && (owner_q == $past(winner)));

  assert_held_read_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !release_ok) |=> held_q && $stable(owner_q));

  assert_no_take_when_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> (grant_o == '0));

  assert_owner_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_ok |=> !held_q);

  assert_foreign_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !wr_hit_i[owner_q]) |=> held_q);

  assert_single_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_lowest_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acquire |-> ((32'(rd_hit_i) & slk_pkg::below_mask(32'(winner))) == 32'h0));

endmodule

// File: rtl/slk_read_return.sv
module slk_read_return #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        took_i,
  output logic [NUM_PORTS*DATA_W-1:0] rdata_o
);

  logic [NUM_PORTS-1:0] took_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) took_q <= '0;
    else         took_q <= took_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_word
    assign rdata_o[p*DATA_W +: DATA_W] = DATA_W'(took_q[p]);
  end

endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*IDX_W-1:0]  port_addr_i,
  input  logic [NUM_PORTS-1:0]        port_rd_i,
  input  logic [NUM_PORTS-1:0]        port_wr_i,
  output logic [NUM_PORTS*DATA_W-1:0] port_rdata_o
);

  logic [NUM_PORTS-1:0] rd_hit    [NUM_LOCKS];
  logic [NUM_PORTS-1:0] wr_hit    [NUM_LOCKS];
  logic [NUM_PORTS-1:0] grant_mat [NUM_LOCKS];
  logic [NUM_PORTS-1:0] port_took;

  // Address decode: which port targets which lock
  always_comb begin
    for (int l = 0; l < NUM_LOCKS; l++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        rd_hit[l][p] = port_rd_i[p] && (port_addr_i[p*IDX_W +: IDX_W] == IDX_W'(l));
        wr_hit[l][p] = port_wr_i[p] && (port_addr_i[p*IDX_W +: IDX_W] == IDX_W'(l));
      end
    end
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    slk_lock_cell #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
    ) cell_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_hit_i (rd_hit[l]),
      .wr_hit_i (wr_hit[l]),
      .grant_o  (grant_mat[l])
    );
  end

  // Collect per-port success across locks
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      port_took[p] = 1'b0;
      for (int l = 0; l < NUM_LOCKS; l++) begin
        port_took[p] = port_took[p] | grant_mat[l][p];
      end
    end
  end

  slk_read_return #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W)
  ) ret_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .took_i  (port_took),
    .rdata_o (port_rdata_o)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_rdata_after_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_rdata_o[p*DATA_W +: DATA_W] != '0) |-> $past(port_rd_i[p]));

    assert_rdata_is_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_rdata_o[p*DATA_W +: DATA_W] <= DATA_W'(1));
  end

endmodule

// File: tb/spinlock_bank_tb_top.sv
module spinlock_bank_tb_top;

  localparam int NP = 3;
  localparam int NL = 16;
  localparam int DW = 32;
  localparam int IW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP*IW-1:0] addr = '0;
  logic [NP-1:0]    rd = '0;
  logic [NP-1:0]    wr = '0;
  logic [NP*DW-1:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;

  bit m_held  [NL];
  int m_owner [NL];

  always #2 clk = ~clk;

  spinlock_bank #(
    .NUM_PORTS (NP),
    .NUM_LOCKS (NL),
    .DATA_W    (DW)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .port_addr_i  (addr),
    .port_rd_i    (rd),
    .port_wr_i    (wr),
    .port_rdata_o (rdata)
  );

  task automatic check(input string req, input int port, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s port %0d: actual %0d expected %0d", req, port, act, exp);
    end
  endtask

  // One access cycle; called at a falling edge, returns at the next one.
  task automatic access(input string req, input logic [NP-1:0] r, input logic [NP-1:0] w,
                        input int a0, input int a1, input int a2);
    int a [NP];
    int want [NP];
    a[0] = a0; a[1] = a1; a[2] = a2;
    for (int p = 0; p < NP; p++) want[p] = 0;
    // expected take results from pre-cycle state
    for (int l = 0; l < NL; l++) begin
      if (!m_held[l]) begin
        for (int p = 0; p < NP; p++) begin
          if (r[p] && a[p] == l) begin
            want[p] = 1;
            m_held[l] = 1'b1;
            m_owner[l] = p;
            break;
          end
        end
      end
    end
    // releases only from the owner of a lock held before this cycle
    for (int p = 0; p < NP; p++) begin
      if (w[p] && m_held[a[p]] && m_owner[a[p]] == p && !(want[0] == 1 && a[0] == a[p] && p != 0)) begin
        if (!((r[0] && a[0] == a[p] && want[0] == 1) || (r[1] && a[1] == a[p] && want[1] == 1) ||
              (r[2] && a[2] == a[p] && want[2] == 1))) begin
          m_held[a[p]] = 1'b0;
          m_owner[a[p]] = -1;
        end
      end
    end
    for (int p = 0; p < NP; p++) addr[p*IW +: IW] = IW'(a[p]);
    rd = r;
    wr = w;
    @(negedge clk);
    for (int p = 0; p < NP; p++) check(req, p, rdata[p*DW +: DW], DW'(want[p]));
    rd = '0;
    wr = '0;
  endtask

  task automatic t_reset;
    for (int p = 0; p < NP; p++) check("R9 reset rdata", p, rdata[p*DW +: DW], '0);
    // every lock is free: port 0 takes each, then frees it
    for (int l = 0; l < NL; l++) begin
      access("R9 R1 free after reset", 3'b001, 3'b000, l, 0, 0);
      access("R4 release sweep", 3'b000, 3'b001, l, 0, 0);
    end
  endtask

  task automatic t_take_and_fail;
    access("R2 take free", 3'b001, 3'b000, 5, 0, 0);
    access("R3 held read fails", 3'b010, 3'b000, 0, 5, 0);
    access("R3 owner reread fails", 3'b001, 3'b000, 5, 0, 0);
    access("R5 foreign write", 3'b000, 3'b010, 0, 5, 0);
    access("R5 still held", 3'b100, 3'b000, 0, 0, 5);
    access("R4 owner release", 3'b000, 3'b001, 5, 0, 0);
    access("R4 free again", 3'b010, 3'b000, 0, 5, 0);
    access("R4 cleanup", 3'b000, 3'b010, 0, 5, 0);
    access("R5 write to free lock", 3'b000, 3'b001, 7, 0, 0);
    access("R5 free lock untouched", 3'b100, 3'b000, 0, 0, 7);
    access("R5 old writer cannot free", 3'b000, 3'b001, 7, 0, 0);
    access("R5 still owned by port 2", 3'b010, 3'b000, 0, 7, 0);
    access("R4 cleanup", 3'b000, 3'b100, 0, 0, 7);
  endtask

  task automatic t_priority;
    access("R6 two contend", 3'b110, 3'b000, 0, 9, 9);
    access("R6 winner owns", 3'b000, 3'b100, 0, 9, 9);
    access("R6 loser could not free", 3'b001, 3'b000, 9, 0, 0);
    access("R6 three contend", 3'b111, 3'b000, 3, 3, 3);
    access("R4 cleanup", 3'b000, 3'b010, 0, 9, 0);
    access("R4 cleanup", 3'b000, 3'b001, 3, 0, 0);
  endtask

  task automatic t_parallel;
    access("R7 distinct locks", 3'b111, 3'b000, 1, 2, 15);
    access("R7 mixed read and write", 3'b001, 3'b110, 4, 2, 15);
    access("R7 check freed", 3'b110, 3'b000, 0, 2, 15);
    access("R7 cleanup", 3'b000, 3'b111, 1, 2, 15);
    access("R4 cleanup", 3'b000, 3'b001, 4, 0, 0);
  endtask

  task automatic t_latency;
    access("R8 read", 3'b010, 3'b000, 0, 12, 0);
    access("R8 idle gives zero", 3'b000, 3'b000, 0, 0, 0);
    access("R4 cleanup", 3'b000, 3'b010, 0, 12, 0);
  endtask

  task automatic t_release_race;
    access("R10 take", 3'b100, 3'b000, 0, 0, 11);
    access("R10 release with read", 3'b001, 3'b100, 11, 0, 11);
    access("R10 freed afterwards", 3'b010, 3'b000, 0, 11, 0);
    access("R4 cleanup", 3'b000, 3'b010, 0, 11, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      m_held[l] = 1'b0;
      m_owner[l] = -1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_take_and_fail();
    t_priority();
    t_parallel();
    t_latency();
    t_release_race();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule